// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge gives a host a narrow window of four 32-bit registers through which it can reach a much larger internal register space. The host does not address target registers directly. It loads a target address into one window register. For a write it also loads a data word into another. It then writes a command word. That command write alone starts one transaction on a simple downstream register bus with request, write-enable, address, write-data, read-data and ready signals.

When the downstream target answers, the bridge raises an acknowledge flag in the command register. For a read, the returned word is already in the read-data register by then. The host collects the result and closes the exchange by writing zero to the command register. The bridge then reads back as all zeros and is ready for the next command.

Host-side timeouts and checks on the target address range sit outside this block.

Top module: `ind_bridge`

## Requirements
- R1: Window registers are selected by byte offset, and an offset whose two low bits are not zero selects none of them. The registers are the command register at 0x0, the target address at 0x4, the read data at 0x8 and the write data at 0xC. A host read returns the selected register on `hst_rdata`, with `hst_rvalid` high, in the cycle after `hst_rd`. The target address and write data registers read back what was last written to them.
- R2: When the bridge is idle, a command write with bit 0 (read) set and bit 1 (write) clear starts exactly one downstream access with `dn_we` low. Bit 1 set with bit 0 clear starts one access with `dn_we` high. The access uses the stored target address and, for writes, the stored write data. The command register reads back these bits in positions 1:0.
- R3: `dn_req` stays high, with `dn_addr`, `dn_we` and `dn_wdata` unchanged, until a cycle in which `dn_ready` is high. `dn_req` is low in the following cycle. There is no internal timeout.
- R4: When a read completes, `dn_rdata` is stored into the read data register and the acknowledge flag (command bit 2) is set on the same clock edge.
- R5: When a write completes, the acknowledge flag is set and the read data register keeps its value.
- R6: A command with bits 0 and 1 both set starts no downstream access. It sets the acknowledge flag one cycle later, so the command reads 0x7, and the read data register keeps its value.
- R7: While an access is in flight or the acknowledge flag is set, any command write with a nonzero bits 1:0 is ignored. It starts no access and leaves the command register unchanged.
- R8: A command write whose bits 1:0 are both zero clears the command register to all zeros and returns the bridge to idle. If an access is in flight at that moment, the access still runs to completion and read data is still stored, but the acknowledge flag is never set.
- R9: Reset clears all four window registers, drops `dn_req` and returns the bridge to idle.
- R10: Host writes to the read data offset have no effect. Rewriting the target address or write data register while an access is in flight does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host write strobe, one cycle per write |
| hst_rd | input | 1 | Host read strobe, one cycle per read |
| hst_addr | input | OFF_W | Host byte offset into the window |
| hst_wdata | input | DW | Host write data |
| hst_rdata | output | DW | Host read data, registered |
| hst_rvalid | output | 1 | High the cycle after a host read |
| dn_req | output | 1 | Downstream request, held until ready |
| dn_we | output | 1 | Downstream write enable |
| dn_addr | output | AW | Downstream target address |
| dn_wdata | output | DW | Downstream write data |
| dn_rdata | input | DW | Downstream read data, valid with ready |
| dn_ready | input | 1 | Downstream completion for the current request |

## Verification
The properties assume that the host issues at most one of `hst_wr` and `hst_rd` in any cycle. They also assume that the downstream target asserts `dn_ready` only while `dn_req` is high, and that it eventually answers every request. The bench's target model raises ready only in a cycle where it sees the request. Its latency is set per scenario, from zero up to several cycles. The host tasks drive a single strobe for one cycle at a time, which keeps the stimulus inside these assumptions. The bench then exercises reads, writes, commands that set both bits, commands that arrive while busy or acknowledged, and a clear written during an access.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } ibr_state_e;

  localparam int REG_CNT   = 4;
  localparam int IDX_CMD   = 0;
  localparam int IDX_TADDR = 1;
  localparam int IDX_RDAT  = 2;
  localparam int IDX_WDAT  = 3;

  localparam int CMD_W       = 3;
  localparam int BIT_RD      = 0;
  localparam int BIT_WR      = 1;
  localparam int BIT_ACK     = 2;
endpackage

// File: rtl/ibr_regs.sv
module ibr_regs #(
  parameter int OFF_W = 4,
  parameter int DW    = 32,
  parameter int AW    = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       hst_wr,
  input  logic                       hst_rd,
  input  logic [OFF_W-1:0]           hst_addr,
  input  logic [DW-1:0]              hst_wdata,
  input  logic [ibr_pkg::CMD_W-1:0]  cmd_view,
  input  logic [DW-1:0]              rdat_view,
  output logic                       cmd_we,
  output logic [AW-1:0]              taddr_q,
  output logic [DW-1:0]              wdat_q,
  output logic [DW-1:0]              hst_rdata,
  output logic                       hst_rvalid
);
  import ibr_pkg::*;

  localparam int IDX_W = OFF_W - 2;

  logic [IDX_W-1:0]   word_idx;
  logic               aligned;
  logic [REG_CNT-1:0] sel;
  logic [DW-1:0]      view [REG_CNT];
  logic [DW-1:0]      rd_mux;

  assign word_idx = hst_addr[OFF_W-1:2];
  assign aligned  = (hst_addr[1:0] == 2'b00);

  // one select line per window register
  for (genvar g = 0; g < REG_CNT; g++) begin : g_sel
    assign sel[g] = aligned && (word_idx == IDX_W'(g));
  end

  assign cmd_we = hst_wr && sel[IDX_CMD];

  always_ff @(posedge clk) begin
    if (rst) begin
      taddr_q <= '0;
      wdat_q  <= '0;
    end else if (hst_wr) begin
      if (sel[IDX_TADDR]) taddr_q <= hst_wdata[AW-1:0];
      if (sel[IDX_WDAT])  wdat_q  <= hst_wdata;
    end
  end

  assign view[IDX_CMD]   = {{(DW-CMD_W){1'b0}}, cmd_view};
  assign view[IDX_TADDR] = DW'(taddr_q);
  assign view[IDX_RDAT]  = rdat_view;
  assign view[IDX_WDAT]  = wdat_q;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < REG_CNT; i++) begin
      if (sel[i]) rd_mux = view[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hst_rdata  <= '0;
      hst_rvalid <= 1'b0;
    end else begin
      hst_rvalid <= hst_rd;
      if (hst_rd) hst_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ibr_ctrl.sv
module ibr_ctrl (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_we,
  input  logic [1:0]                cmd_bits,
  input  logic                      done,
  output logic                      start,
  output logic                      start_we,
  output logic [ibr_pkg::CMD_W-1:0] cmd_q
);
  import ibr_pkg::*;

  ibr_state_e state;
  logic       rd_q, wr_q, ack_q;
  logic       clr_req, single, both;

  assign clr_req  = cmd_we && (cmd_bits == 2'b00);
  assign single   = (cmd_bits == 2'b01) || (cmd_bits == 2'b10);
  assign both     = (cmd_bits == 2'b11);
  assign start    = (state == ST_IDLE) && cmd_we && single;
  assign start_we = cmd_bits[BIT_WR];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_we && (single || both)) begin
            rd_q <= cmd_bits[BIT_RD];
            wr_q <= cmd_bits[BIT_WR];
            if (both) begin
              ack_q <= 1'b1;
              state <= ST_DONE;
            end else begin
              state <= ST_BUSY;
            end
          end
        end
        ST_BUSY: begin
          if (clr_req) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
          end
          if (done) begin
            if (clr_req || !(rd_q || wr_q)) begin
              state <= ST_IDLE;
            end else begin
              ack_q <= 1'b1;
              state <= ST_DONE;
            end
          end
        end
        ST_DONE: begin
          if (clr_req) begin
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
            ack_q <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_q = {ack_q, wr_q, rd_q};
endmodule

// File: rtl/ibr_dnm.sv
module ibr_dnm #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] taddr,
  input  logic [DW-1:0] wdat,
  input  logic          dn_ready,
  input  logic [DW-1:0] dn_rdata,
  output logic          dn_req,
  output logic          dn_we,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  output logic          done,
  output logic [DW-1:0] rdat_q
);
  assign done = dn_req && dn_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_req   <= 1'b0;
      dn_we    <= 1'b0;
      dn_addr  <= '0;
      dn_wdata <= '0;
      rdat_q   <= '0;
    end else if (done) begin
      dn_req <= 1'b0;
      if (!dn_we) rdat_q <= dn_rdata;
    end else if (start && !dn_req) begin
      dn_req   <= 1'b1;
      dn_we    <= start_we;
      dn_addr  <= taddr;
      dn_wdata <= wdat;
    end
  end
endmodule

// File: rtl/ind_bridge.sv
module ind_bridge #(
  parameter int OFF_W = 4,
  parameter int DW    = 32,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hst_wr,
  input  logic             hst_rd,
  input  logic [OFF_W-1:0] hst_addr,
  input  logic [DW-1:0]    hst_wdata,
  output logic [DW-1:0]    hst_rdata,
  output logic             hst_rvalid,
  output logic             dn_req,
  output logic             dn_we,
  output logic [AW-1:0]    dn_addr,
  output logic [DW-1:0]    dn_wdata,
  input  logic [DW-1:0]    dn_rdata,
  input  logic             dn_ready
);
  import ibr_pkg::*;

  logic              cmd_we, start, start_we, done;
  logic [CMD_W-1:0]  cmd_view;
  logic [AW-1:0]     taddr_q;
  logic [DW-1:0]     wdat_q, rdat_q;

  ibr_regs #(.OFF_W(OFF_W), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .cmd_view(cmd_view), .rdat_view(rdat_q),
    .cmd_we(cmd_we), .taddr_q(taddr_q), .wdat_q(wdat_q),
    .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid)
  );

  ibr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_bits(hst_wdata[1:0]),
    .done(done), .start(start), .start_we(start_we), .cmd_q(cmd_view)
  );

  ibr_dnm #(.DW(DW), .AW(AW)) u_dnm (
    .clk(clk), .rst(rst), .start(start), .start_we(start_we),
    .taddr(taddr_q), .wdat(wdat_q), .dn_ready(dn_ready), .dn_rdata(dn_rdata),
    .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .done(done), .rdat_q(rdat_q)
  );
endmodule

// File: rtl/ibr_chk.sv
module ibr_chk #(
  parameter int OFF_W = 4,
  parameter int DW    = 32,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             hst_wr,
  input logic             hst_rd,
  input logic [OFF_W-1:0] hst_addr,
  input logic [1:0]       cmd_lo,
  input logic             hst_rvalid,
  input logic             dn_req,
  input logic             dn_we,
  input logic [AW-1:0]    dn_addr,
  input logic [DW-1:0]    dn_wdata,
  input logic             dn_ready,
  input logic             ack
);
  logic cmd_hit;
  assign cmd_hit = hst_wr && (hst_addr == '0);

  // R1
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    hst_rd |=> hst_rvalid);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_req && !dn_ready) |=> (dn_req && $stable(dn_addr) && $stable(dn_we) && $stable(dn_wdata)));

  // R3
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_req && dn_ready) |=> !dn_req);

  // R6
  ack_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> ($past(dn_req && dn_ready) || $past(cmd_hit && (cmd_lo == 2'b11))));

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !$rose(dn_req));

  // R8
  clear_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && (cmd_lo == 2'b00)) |=> !ack);

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!dn_req && !ack));
endmodule

bind ind_bridge ibr_chk #(.OFF_W(OFF_W), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
  .cmd_lo(hst_wdata[1:0]), .hst_rvalid(hst_rvalid), .dn_req(dn_req), .dn_we(dn_we),
  .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ready(dn_ready), .ack(cmd_view[2])
);

// File: tb/sim_ind_bridge.sv
module sim_ind_bridge;
  localparam int OFF_W = 4;
  localparam int DW    = 32;
  localparam int AW    = 32;
  localparam logic [OFF_W-1:0] O_CMD = 4'h0, O_TA = 4'h4, O_RD = 4'h8, O_WD = 4'hC;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } txn_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             hst_wr = 1'b0, hst_rd = 1'b0;
  logic [OFF_W-1:0] hst_addr = '0;
  logic [DW-1:0]    hst_wdata = '0;
  logic [DW-1:0]    hst_rdata;
  logic             hst_rvalid;
  logic             dn_req, dn_we;
  logic [AW-1:0]    dn_addr;
  logic [DW-1:0]    dn_wdata;
  logic [DW-1:0]    dn_rdata = '0;
  logic             dn_ready = 1'b0;

  int   checks = 0, errors = 0, acc_cnt = 0, lat = 0, cnt = 0;
  bit   fin = 0;
  txn_t exp_q[$];

  always #5 clk = ~clk;

  ind_bridge #(.OFF_W(OFF_W), .DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid),
    .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_rdata(dn_rdata), .dn_ready(dn_ready)
  );

  function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // target model and monitor: ready after lat cycles, compare against scoreboard
  always @(negedge clk) begin
    if (dn_req) begin
      if (cnt == lat) begin
        dn_ready = 1'b1;
        dn_rdata = model(dn_addr);
        acc_cnt++;
        cnt = 0;
        if (exp_q.size() == 0) begin
          chk(0, "R7 unexpected downstream access", DW'(dn_addr), '0);
        end else begin
          txn_t e;
          e = exp_q.pop_front();
          chk(dn_we == e.we, "R2 access direction", DW'(dn_we), DW'(e.we));
          chk(dn_addr == e.addr, "R10 access address", DW'(dn_addr), DW'(e.addr));
          if (e.we) chk(dn_wdata == e.wdata, "R2 access write data", dn_wdata, e.wdata);
        end
      end else begin
        dn_ready = 1'b0;
        cnt++;
      end
    end else begin
      dn_ready = 1'b0;
      cnt = 0;
    end
  end

  task automatic hwrite(input logic [OFF_W-1:0] off, input logic [DW-1:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = off; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic hread(input logic [OFF_W-1:0] off, output logic [DW-1:0] d);
    @(negedge clk);
    hst_rd = 1'b1; hst_addr = off;
    @(negedge clk);
    hst_rd = 1'b0;
    d = hst_rdata;
    chk(hst_rvalid, "R1 read valid", DW'(hst_rvalid), 1);
  endtask

  task automatic expect_reg(input logic [OFF_W-1:0] off, input logic [DW-1:0] exp, input string tag);
    logic [DW-1:0] v;
    hread(off, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic wait_ack(input string tag);
    logic [DW-1:0] v;
    v = '0;
    for (int i = 0; i < 60; i++) begin
      hread(O_CMD, v);
      if (v[2]) break;
    end
    chk(v[2], tag, v, 32'h4);
  endtask

  task automatic push(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    txn_t t;
    t.we = we; t.addr = a; t.wdata = d;
    exp_q.push_back(t);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk(dn_req == 1'b0, "R9 request low after reset", DW'(dn_req), 0);
    expect_reg(O_CMD, 0, "R9 command cleared");
    expect_reg(O_TA,  0, "R9 address cleared");
    expect_reg(O_RD,  0, "R9 read data cleared");
    expect_reg(O_WD,  0, "R9 write data cleared");

    // R2 R5 write access
    lat = 0;
    hwrite(O_WD, 32'hDEADBEEF);
    hwrite(O_TA, 32'h0000_0100);
    expect_reg(O_TA, 32'h100, "R1 address readback");
    expect_reg(O_WD, 32'hDEADBEEF, "R1 write data readback");
    push(1'b1, 32'h100, 32'hDEADBEEF);
    hwrite(O_CMD, 32'h2);
    wait_ack("R5 ack after write");
    expect_reg(O_CMD, 32'h6, "R5 command after write");
    expect_reg(O_RD, 0, "R5 read data kept");
    chk(dn_req == 1'b0, "R3 request dropped", DW'(dn_req), 0);
    hwrite(O_CMD, 0);
    expect_reg(O_CMD, 0, "R8 cleared after write");

    // R4 read access with latency
    lat = 3;
    hwrite(O_TA, 32'h0000_0204);
    push(1'b0, 32'h204, '0);
    hwrite(O_CMD, 32'h1);
    wait_ack("R4 ack after read");
    expect_reg(O_CMD, 32'h5, "R4 command after read");
    expect_reg(O_RD, model(32'h204), "R4 read data captured");
    hwrite(O_CMD, 0);

    // R7 commands while busy and while acknowledged
    lat = 6;
    base = acc_cnt;
    hwrite(O_TA, 32'h0000_0a08);
    push(1'b0, 32'ha08, '0);
    hwrite(O_CMD, 32'h1);
    hwrite(O_CMD, 32'h2);
    wait_ack("R7 ack after busy command");
    expect_reg(O_CMD, 32'h5, "R7 busy command ignored");
    hwrite(O_CMD, 32'h2);
    expect_reg(O_CMD, 32'h5, "R7 command during ack ignored");
    repeat (10) @(negedge clk);
    chk(acc_cnt == base + 1, "R7 single access", DW'(acc_cnt - base), 1);
    hwrite(O_CMD, 0);

    // R6 both bits set
    base = acc_cnt;
    hwrite(O_CMD, 32'h3);
    expect_reg(O_CMD, 32'h7, "R6 both bits acknowledged");
    expect_reg(O_RD, model(32'ha08), "R6 read data kept");
    repeat (10) @(negedge clk);
    chk(acc_cnt == base, "R6 no access", DW'(acc_cnt - base), 0);
    hwrite(O_CMD, 0);
    expect_reg(O_CMD, 0, "R8 cleared after no-op");

    // R8 clear while an access is in flight
    lat = 8;
    hwrite(O_TA, 32'h0000_0300);
    push(1'b0, 32'h300, '0);
    hwrite(O_CMD, 32'h1);
    hwrite(O_CMD, 32'h0);
    expect_reg(O_CMD, 0, "R8 clear during access");
    repeat (15) @(negedge clk);
    expect_reg(O_CMD, 0, "R8 no ack after abandoned access");
    expect_reg(O_RD, model(32'h300), "R8 read data still stored");

    // R10 register rewrites during an access, write to read data offset
    lat = 5;
    hwrite(O_WD, 32'h1234_5678);
    hwrite(O_TA, 32'h0000_0440);
    push(1'b1, 32'h440, 32'h1234_5678);
    hwrite(O_CMD, 32'h2);
    hwrite(O_TA, 32'h0000_0ff0);
    hwrite(O_WD, 32'hCAFE_0000);
    hwrite(O_RD, 32'h5555_5555);
    wait_ack("R10 ack after rewritten access");
    expect_reg(O_RD, model(32'h300), "R10 read data offset not writable");
    expect_reg(O_TA, 32'h0ff0, "R10 new address stored");
    hwrite(O_CMD, 0);

    // R1 unaligned offset selects nothing
    expect_reg(4'h5, 0, "R1 unaligned offset");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", DW'(exp_q.size()), 0);
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog expired act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule